// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a physical address through a small set of large, software-programmed translation windows. It holds eight window descriptors. The lower half of the set serves instruction fetches and the upper half serves data loads and stores. Each descriptor has two 32-bit words. The first word gives the window base, a length field, and separate enables for privileged and unprivileged mode. The second word gives the physical base and a two-bit protection code.

A request is presented with a single-cycle valid strobe together with its address, its side (fetch or data), its direction (read or write) and its privilege. The result appears on the registered outputs exactly one cycle later. The result is a hit flag, the translated physical address, and a grant level of denied, read-only or read-write. Software loads descriptors one word at a time through a write port. A write that shares a clock edge with a lookup is seen by the following lookup and not by that one.

Window size is variable. The length field widens a match mask upward from a fixed 128 KiB minimum, so one descriptor covers a naturally aligned region of 128 KiB up to 256 MiB.

Top module: `blk_xlate_unit`

## Requirements
- R1: `rsp_vld` is high in the cycle right after each clock edge at which `req_vld` was sampled high, and low after every edge at which it was low; the other response outputs are valid while `rsp_vld` is high.
- R2: A fetch (`req_fetch`=1) considers only descriptors 0 to 3, and a data access (`req_fetch`=0) considers only descriptors 4 to 7.
- R3: In unprivileged mode (`req_user`=1) a descriptor is eligible only if bit 0 of its first word is set. In privileged mode it is eligible only if bit 1 of its first word is set.
- R4: The match mask is the length field (first word bits 12:2) shifted left by 17, ORed with 0x1FFFF. A descriptor matches when the address and the window base (first word bits 31:17, with zeros below) agree on every bit outside the mask.
- R5: On a hit, `rsp_paddr` takes the address bits inside the mask and the physical base bits (second word bits 31:17, with zeros below) outside it.
- R6: The protection code sits in second word bits 1:0. Code 00 gives grant 0 (denied). Code 10 gives grant 2 (read-write). Codes 01 and 11 give grant 1 (read-only) to a read and grant 0 to a write. Grant 3 never appears.
- R7: When no eligible descriptor matches, `rsp_hit`=0, `rsp_grant`=0 and `rsp_paddr`=0.
- R8: When several eligible descriptors match, the one with the lowest index decides the address and the grant.
- R9: With `cfg_we`=1, `cfg_wdata` is stored into descriptor `cfg_idx`: into its first word when `cfg_word_hi`=1, and into its second word otherwise. A write made at the same edge as a lookup takes effect from the next lookup on.
- R10: Reset clears every descriptor, so that each is ineligible, and drives `rsp_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_idx | input | 3 | Descriptor index being written |
| cfg_word_hi | input | 1 | 1 selects the first word (base, length, enables); 0 selects the second word (physical base, protection) |
| cfg_wdata | input | 32 | Word to store |
| req_vld | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_write | input | 1 | 1 for a write |
| req_user | input | 1 | 1 for unprivileged mode |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A descriptor matched |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_grant | output | 2 | 0 denied, 1 read-only, 2 read-write |

## Verification
The assertions assume that the request fields are stable around the sampling edge. The check that the low 17 address bits pass through unchanged compares against the address held at the edge that carried `req_vld`, so that address must belong to that same request. The bench changes every input at the falling clock edge and keeps each request strobe high for one cycle only. It writes descriptors either in cycles with no lookup, or, in one deliberate case, together with a lookup to expose the write ordering. It never issues a fetch marked as a write to data descriptors, so each access keeps a single meaning on its side.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [1:0] {
      GRANT_NONE = 2'd0,
      GRANT_RO   = 2'd1,
      GRANT_RW   = 2'd2
   } grant_e;

   localparam logic [1:0] PROT_DENY = 2'b00;
   localparam logic [1:0] PROT_RO_A = 2'b01;
   localparam logic [1:0] PROT_RW   = 2'b10;
   localparam logic [1:0] PROT_RO_B = 2'b11;

   // Bit positions inside the first descriptor word, below the page field.
   localparam int unsigned EN_USR_BIT = 0;
   localparam int unsigned EN_SUP_BIT = 1;
   localparam int unsigned LEN_LSB    = 2;

   function automatic grant_e grant_of(input logic [1:0] prot, input logic is_write);
      grant_e g;
      unique case (prot)
         PROT_DENY: g = GRANT_NONE;
         PROT_RW:   g = GRANT_RW;
         PROT_RO_A,
         PROT_RO_B: g = is_write ? GRANT_NONE : GRANT_RO;
         default:   g = GRANT_NONE;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/blkx_regfile.sv
module blkx_regfile
   import blkx_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFFSET_W  = 17,
   parameter int unsigned LEN_W     = 11,
   localparam int unsigned IDX_W    = $clog2(NUM_PAIRS),
   localparam int unsigned PAGE_W   = DATA_W - OFFSET_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic                               wr_hi,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_PAIRS-1:0][PAGE_W-1:0]   base_o,
   output logic [NUM_PAIRS-1:0][LEN_W-1:0]    len_o,
   output logic [NUM_PAIRS-1:0]               en_sup_o,
   output logic [NUM_PAIRS-1:0]               en_usr_o,
   output logic [NUM_PAIRS-1:0][PAGE_W-1:0]   phys_o,
   output logic [NUM_PAIRS-1:0][1:0]          prot_o
);

   localparam int unsigned LEN_MSB = LEN_LSB + LEN_W - 1;

   // Elaboration-time parameter checks
   if (NUM_PAIRS < 2 || (NUM_PAIRS % 2) != 0 || (1 << IDX_W) != NUM_PAIRS) begin : g_bad_pairs
      $error("blkx_regfile: NUM_PAIRS must be an even power of two");
   end
   if (LEN_MSB >= OFFSET_W) begin : g_bad_len
      $error("blkx_regfile: length field does not fit below the page field");
   end
   if (OFFSET_W + LEN_W > DATA_W) begin : g_bad_mask
      $error("blkx_regfile: widened mask exceeds the word width");
   end

   logic [NUM_PAIRS-1:0][PAGE_W-1:0] base_q;
   logic [NUM_PAIRS-1:0][LEN_W-1:0]  len_q;
   logic [NUM_PAIRS-1:0]             en_sup_q;
   logic [NUM_PAIRS-1:0]             en_usr_q;
   logic [NUM_PAIRS-1:0][PAGE_W-1:0] phys_q;
   logic [NUM_PAIRS-1:0][1:0]        prot_q;

   // Field bits without storage; folded so that they are visibly consumed.
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[OFFSET_W-1:LEN_LSB];

   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[i]   <= '0;
            len_q[i]    <= '0;
            en_sup_q[i] <= 1'b0;
            en_usr_q[i] <= 1'b0;
            phys_q[i]   <= '0;
            prot_q[i]   <= PROT_DENY;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            if (wr_hi) begin
               base_q[i]   <= wr_data[DATA_W-1:OFFSET_W];
               len_q[i]    <= wr_data[LEN_MSB:LEN_LSB];
               en_sup_q[i] <= wr_data[EN_SUP_BIT];
               en_usr_q[i] <= wr_data[EN_USR_BIT];
            end else begin
               phys_q[i] <= wr_data[DATA_W-1:OFFSET_W];
               prot_q[i] <= wr_data[1:0];
            end
         end
      end
   end

   assign base_o   = base_q;
   assign len_o    = len_q;
   assign en_sup_o = en_sup_q;
   assign en_usr_o = en_usr_q;
   assign phys_o   = phys_q;
   assign prot_o   = prot_q;

   AST_LOWER_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi) |=> (prot_o[$past(wr_idx)] == $past(wr_data[1:0]))) // R9
      else $error("lower-word write not stored");

   AST_UPPER_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi) |=> (en_usr_o[$past(wr_idx)] == $past(wr_data[EN_USR_BIT]))) // R9
      else $error("upper-word write not stored");

endmodule

// File: rtl/blkx_pair_match.sv
module blkx_pair_match #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OFFSET_W = 17,
   parameter int unsigned LEN_W    = 11,
   localparam int unsigned PAGE_W  = ADDR_W - OFFSET_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              side_ok,
   input  logic              is_user,
   input  logic [PAGE_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic              en_sup,
   input  logic              en_usr,
   input  logic [PAGE_W-1:0] phys,
   output logic              hit,
   output logic [ADDR_W-1:0] paddr
);

   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] base_full;
   logic [ADDR_W-1:0] phys_full;
   logic              mode_ok;
   logic              addr_ok;

   // Mask: a fixed low window plus the length field widening it upward.
   assign mask = ({{(ADDR_W-LEN_W){1'b0}}, len} << OFFSET_W)
               | {{(ADDR_W-OFFSET_W){1'b0}}, {OFFSET_W{1'b1}}};

   assign base_full = {base, {OFFSET_W{1'b0}}};
   assign phys_full = {phys, {OFFSET_W{1'b0}}};

   assign mode_ok = is_user ? en_usr : en_sup;
   assign addr_ok = ((addr ^ base_full) & ~mask) == '0;
   assign hit     = side_ok && mode_ok && addr_ok;

   assign paddr = (addr & mask) | (phys_full & ~mask);

endmodule

// File: rtl/blkx_pick.sv
module blkx_pick
   import blkx_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned ADDR_W    = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PAIRS-1:0]             hit_i,
   input  logic [NUM_PAIRS-1:0][ADDR_W-1:0] paddr_i,
   input  logic [NUM_PAIRS-1:0][1:0]        prot_i,
   input  logic                             is_write,
   output logic                             hit_o,
   output logic [ADDR_W-1:0]                paddr_o,
   output grant_e                           grant_o
);

   logic [NUM_PAIRS:0]   seen;
   logic [NUM_PAIRS-1:0] win;
   logic [ADDR_W-1:0]    paddr_acc;
   logic [1:0]           prot_acc;

   assign seen[0] = 1'b0;

   // Lowest index wins: each slot is blocked by any hit below it.
   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chain
      assign win[i]    = hit_i[i] & ~seen[i];
      assign seen[i+1] = seen[i] | hit_i[i];
   end

   always_comb begin
      paddr_acc = '0;
      prot_acc  = '0;
      for (int i = 0; i < NUM_PAIRS; i++) begin
         paddr_acc = paddr_acc | ({ADDR_W{win[i]}} & paddr_i[i]);
         prot_acc  = prot_acc  | ({2{win[i]}} & prot_i[i]);
      end
   end

   assign hit_o   = seen[NUM_PAIRS];
   assign paddr_o = paddr_acc;
   assign grant_o = hit_o ? grant_of(prot_acc, is_write) : GRANT_NONE;

   AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win)) // R8
      else $error("more than one descriptor selected");

   AST_WINNER_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (win & ~hit_i) == '0) // R8
      else $error("selected descriptor did not match");

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[0] |-> win[0]) // R8
      else $error("descriptor 0 matched but lost");

endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit
   import blkx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned OFFSET_W  = 17,
   parameter int unsigned LEN_W     = 11,
   localparam int unsigned IDX_W    = $clog2(NUM_PAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_word_hi,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_fetch,
   input  logic              req_write,
   input  logic              req_user,
   output logic              rsp_vld,
   output logic              rsp_hit,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [1:0]        rsp_grant
);

   localparam int unsigned HALF   = NUM_PAIRS / 2;
   localparam int unsigned PAGE_W = ADDR_W - OFFSET_W;

   logic [NUM_PAIRS-1:0][PAGE_W-1:0] base;
   logic [NUM_PAIRS-1:0][LEN_W-1:0]  len;
   logic [NUM_PAIRS-1:0]             en_sup;
   logic [NUM_PAIRS-1:0]             en_usr;
   logic [NUM_PAIRS-1:0][PAGE_W-1:0] phys;
   logic [NUM_PAIRS-1:0][1:0]        prot;

   logic [NUM_PAIRS-1:0]             pair_hit;
   logic [NUM_PAIRS-1:0][ADDR_W-1:0] pair_paddr;

   logic                             sel_hit;
   logic [ADDR_W-1:0]                sel_paddr;
   grant_e                           sel_grant;

   blkx_regfile #(
      .NUM_PAIRS (NUM_PAIRS),
      .DATA_W    (ADDR_W),
      .OFFSET_W  (OFFSET_W),
      .LEN_W     (LEN_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_hi    (cfg_word_hi),
      .wr_data  (cfg_wdata),
      .base_o   (base),
      .len_o    (len),
      .en_sup_o (en_sup),
      .en_usr_o (en_usr),
      .phys_o   (phys),
      .prot_o   (prot)
   );

   // Lower half of the slots serves fetches, upper half serves data.
   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      logic side_ok;
      if (i < HALF) begin : g_fetch_side
         assign side_ok = req_fetch;
      end else begin : g_data_side
         assign side_ok = ~req_fetch;
      end

      blkx_pair_match #(
         .ADDR_W   (ADDR_W),
         .OFFSET_W (OFFSET_W),
         .LEN_W    (LEN_W)
      ) u_match (
         .addr    (req_addr),
         .side_ok (side_ok),
         .is_user (req_user),
         .base    (base[i]),
         .len     (len[i]),
         .en_sup  (en_sup[i]),
         .en_usr  (en_usr[i]),
         .phys    (phys[i]),
         .hit     (pair_hit[i]),
         .paddr   (pair_paddr[i])
      );
   end

   blkx_pick #(
      .NUM_PAIRS (NUM_PAIRS),
      .ADDR_W    (ADDR_W)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (pair_hit),
      .paddr_i  (pair_paddr),
      .prot_i   (prot),
      .is_write (req_write),
      .hit_o    (sel_hit),
      .paddr_o  (sel_paddr),
      .grant_o  (sel_grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_paddr <= '0;
         rsp_grant <= GRANT_NONE;
      end else begin
         rsp_vld <= req_vld;
         if (req_vld) begin
            rsp_hit   <= sel_hit;
            rsp_paddr <= sel_paddr;
            rsp_grant <= sel_grant;
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld) // R1
      else $error("request without response");

   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld) // R1
      else $error("response without request");

   AST_FETCH_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      req_fetch |-> (pair_hit[NUM_PAIRS-1:HALF] == '0)) // R2
      else $error("data descriptor matched a fetch");

   AST_DATA_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !req_fetch |-> (pair_hit[HALF-1:0] == '0)) // R2
      else $error("fetch descriptor matched a data access");

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_hit) |-> (rsp_paddr[OFFSET_W-1:0] == $past(req_addr[OFFSET_W-1:0]))) // R5
      else $error("in-window offset altered");

   AST_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> (rsp_grant != 2'd3)) // R6
      else $error("illegal grant code");

   AST_WRITE_NOT_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_write) |=> (rsp_grant != GRANT_RO)) // R6
      else $error("write granted read-only");

   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && !rsp_hit) |-> (rsp_grant == GRANT_NONE && rsp_paddr == '0)) // R7
      else $error("miss carries data");

endmodule

// File: tb/blk_xlate_unit_bench.sv
module blk_xlate_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_idx;
   logic        cfg_word_hi;
   logic [31:0] cfg_wdata;
   logic        req_vld;
   logic [31:0] req_addr;
   logic        req_fetch;
   logic        req_write;
   logic        req_user;
   logic        rsp_vld;
   logic        rsp_hit;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_grant;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   blk_xlate_unit u_blk_xlate_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_idx     (cfg_idx),
      .cfg_word_hi (cfg_word_hi),
      .cfg_wdata   (cfg_wdata),
      .req_vld     (req_vld),
      .req_addr    (req_addr),
      .req_fetch   (req_fetch),
      .req_write   (req_write),
      .req_user    (req_user),
      .rsp_vld     (rsp_vld),
      .rsp_hit     (rsp_hit),
      .rsp_paddr   (rsp_paddr),
      .rsp_grant   (rsp_grant)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        fetch;
      logic        write;
      logic        user;
      logic        hit;
      logic [31:0] paddr;
      logic [1:0]  grant;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{32'h1000_1234, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_1234, 2'd2, 4'd5}, // R5 slot0 128K window
      '{32'h1000_1234, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 2'd0, 4'd3}, // R3 slot0 not user-enabled
      '{32'h2ABC_DEF0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h3ABC_DEF0, 2'd1, 4'd4}, // R4 256M window, code 01 read
      '{32'h2ABC_DEF0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 4'd2}, // R2 fetch slot ignored for data
      '{32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b1, 32'h4000_0040, 2'd1, 4'd8}, // R8 slot4 beats slot5
      '{32'h1000_0040, 1'b0, 1'b1, 1'b1, 1'b1, 32'h4000_0040, 2'd0, 4'd6}, // R6 code 11 write denied
      '{32'h1000_0040, 1'b0, 1'b1, 1'b0, 1'b1, 32'h5000_0040, 2'd2, 4'd3}, // R3 slot4 not priv-enabled
      '{32'h1015_5555, 1'b0, 1'b0, 1'b0, 1'b1, 32'h5015_5555, 2'd2, 4'd4}, // R4 2M window inside
      '{32'h1025_5555, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 2'd0, 4'd7}, // R7 just outside 2M
      '{32'h6007_FFFC, 1'b0, 1'b1, 1'b1, 1'b1, 32'h7007_FFFC, 2'd0, 4'd6}, // R6 code 00 hit, denied
      '{32'h6008_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 2'd0, 4'd4}, // R4 512K boundary
      '{32'h1000_1234, 1'b0, 1'b0, 1'b0, 1'b1, 32'h5000_1234, 2'd2, 4'd2}, // R2 data side uses slot5
      '{32'h2000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h3000_0000, 2'd0, 4'd6}  // R6 code 01 write denied
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int idx, input bit hi, input logic [31:0] data);
      @(negedge clk);
      cfg_we      = 1'b1;
      cfg_idx     = 3'(idx);
      cfg_word_hi = hi;
      cfg_wdata   = data;
      @(negedge clk);
      cfg_we      = 1'b0;
   endtask

   // Returns at the falling edge after the response register loads.
   task automatic lookup(input logic [31:0] a, input logic f, input logic w, input logic u);
      @(negedge clk);
      req_vld   = 1'b1;
      req_addr  = a;
      req_fetch = f;
      req_write = w;
      req_user  = u;
      @(negedge clk);
      req_vld   = 1'b0;
   endtask

   task automatic check_rsp(input string req, input logic h, input logic [31:0] pa,
                            input logic [1:0] g);
      chk(req, "rsp_vld",   32'(rsp_vld),   32'd1);
      chk(req, "rsp_hit",   32'(rsp_hit),   32'(h));
      chk(req, "rsp_paddr", rsp_paddr,      pa);
      chk(req, "rsp_grant", 32'(rsp_grant), 32'(g));
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cfg_we = 1'b0; cfg_idx = '0; cfg_word_hi = 1'b0; cfg_wdata = '0;
      req_vld = 1'b0; req_addr = '0; req_fetch = 1'b0; req_write = 1'b0; req_user = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "rsp_vld in reset", 32'(rsp_vld), 32'd0);
      rst_n = 1'b1;

      // R10: cleared descriptors never match
      lookup(32'h1000_1234, 1'b1, 1'b0, 1'b0);
      check_rsp("R10", 1'b0, 32'h0, 2'd0);

      // R9: descriptor programming (first word: base | len<<2 | sup<<1 | usr)
      cfg_write(0, 1'b1, 32'h1000_0002); cfg_write(0, 1'b0, 32'h8000_0002);
      cfg_write(1, 1'b1, 32'h2000_1FFF); cfg_write(1, 1'b0, 32'h3000_0001);
      cfg_write(4, 1'b1, 32'h1000_0001); cfg_write(4, 1'b0, 32'h4000_0003);
      cfg_write(5, 1'b1, 32'h1000_003F); cfg_write(5, 1'b0, 32'h5000_0002);
      cfg_write(6, 1'b1, 32'h6000_000F); cfg_write(6, 1'b0, 32'h7000_0000);

      for (int i = 0; i < NV; i++) begin
         lookup(VECS[i].addr, VECS[i].fetch, VECS[i].write, VECS[i].user);
         check_rsp($sformatf("R%0d vec%0d", VECS[i].req, i),
                   VECS[i].hit, VECS[i].paddr, VECS[i].grant);
      end

      // R1: strobe drops one cycle after an idle request cycle
      @(negedge clk);
      chk("R1", "rsp_vld idle", 32'(rsp_vld), 32'd0);

      // R9: write to slot6 second word at the same edge as a lookup hitting it
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'd6; cfg_word_hi = 1'b0; cfg_wdata = 32'h7000_0002;
      req_vld = 1'b1; req_addr = 32'h6000_0010; req_fetch = 1'b0; req_write = 1'b0; req_user = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_vld = 1'b0;
      check_rsp("R9 same-edge", 1'b1, 32'h7000_0010, 2'd0);
      lookup(32'h6000_0010, 1'b0, 1'b0, 1'b1);
      check_rsp("R9 next", 1'b1, 32'h7000_0010, 2'd2);

      // R10: reset again wipes descriptors
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10", "rsp_vld in reset", 32'(rsp_vld), 32'd0);
      rst_n = 1'b1;
      lookup(32'h1000_1234, 1'b1, 1'b0, 1'b0);
      check_rsp("R10 after reset", 1'b0, 32'h0, 2'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule